// File: doc/BRIEF.md
# Dual Cash Drawer Release Controller

This block sits on a small host I/O bus and fires the release solenoids of two cash drawers. The host writes a request strobe into a control register. The block then raises the matching open output for a fixed interval. A two-bit configuration input selects one of four interval lengths, and the interval is timed in whole milliseconds from a prescaled system clock. An interlock allows only one drawer output to be energised at a time. A request for the other drawer is held until the running pulse has ended.

Each drawer also has a status input that reports whether it is open or closed. Drawers differ in the sense of this signal, so each channel has a polarity input that inverts the raw level when it is high. The host reads the corrected status of both drawers from a separate status register. It reads which open outputs are active from the control register.

All inputs are assumed to be synchronous to `clk`. The host reads with a combinational read path: `bus_rdata` is valid in the same cycle as `bus_rd`.

Top module: `drawer_pulse_ctrl`

## Requirements
- R1: A write to address 0x328 with bit 4 set drives `drw_open[0]` (drawer 1) high from the cycle after the write. A write there with bit 5 set does the same for `drw_open[1]` (drawer 2).
- R2: The pulse lasts exactly ms × (CLK_HZ/1000) cycles. `dur_sel` is sampled when the pulse starts, and its codes select the length: 2'b00 = 140 ms, 2'b01 = 100 ms, 2'b10 = 180 ms, 2'b11 = 220 ms.
- R3: `drw_open[0]` and `drw_open[1]` are never high in the same cycle.
- R4: A request for one drawer made while the other drawer's pulse runs is kept pending. It starts after exactly one idle cycle once that pulse ends.
- R5: A request for a drawer whose pulse is already running is ignored and does not lengthen the pulse.
- R6: When one write sets bits 4 and 5 while both outputs are idle, drawer 1 starts first and drawer 2 is held pending.
- R7: The control bits are self-clearing strobes, so writing 0 has no effect. A read of 0x328 returns `drw_open[0]` in bit 4 and `drw_open[1]` in bit 5, with all other bits 0.
- R8: A read of 0x32D returns `drw_sense[0]^pol_inv[0]` in bit 3 and `drw_sense[1]^pol_inv[1]` in bit 2, with all other bits 0. With the polarity input low, a status of 0 means the drawer is closed.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low, and it is 0 on a read of any other address.
- R10: While `rst_n` is low at a clock edge, both open outputs go low and any pending request is dropped.
- R11: Writes to any address other than 0x328 start no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| dur_sel | input | 2 | Pulse length code |
| pol_inv | input | 2 | Per-drawer status inversion (bit 0 = drawer 1) |
| drw_sense | input | 2 | Raw drawer status (bit 0 = drawer 1) |
| drw_open | output | 2 | Solenoid open outputs (bit 0 = drawer 1) |

## Verification
The bench goes after these corner cases:
- **Interval length.** It times every duration code to the cycle. A prescaler or terminal count that is off by one would give pulses one millisecond or one cycle too long or too short.
- **Overlapping requests.** It sends a request for the other drawer while a pulse runs, and also a repeat request for the running drawer. A faulty interlock would overlap the two outputs or drop the pending drawer. A faulty repeat filter would restart or stretch the pulse.
- **Same-write request.** It writes both bits in one write. Wrong priority would open drawer 2 first.
- **Status polarity.** It walks all sense and polarity combinations. Swapped status bits or a missing inversion would show up as wrong read data.
- **Reset during a pulse.** It resets in the middle of a pulse with a request pending. A design that kept pending state across reset would fire a drawer afterwards.

// File: rtl/drw_pkg.sv
// Package: shared addresses, bit positions and the pulse length table
// for the dual cash drawer release controller.
package drw_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 10'h328;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 10'h32D;
    localparam int CTRL_BIT_D1 = 4;
    localparam int CTRL_BIT_D2 = 5;
    localparam int STAT_BIT_D1 = 3;
    localparam int MAX_MS      = 220;
    localparam int MS_W        = $clog2(MAX_MS + 1);

    // Maps a duration code to the pulse length in milliseconds
    function automatic int unsigned pulse_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 140;
            2'b01:   return 100;
            2'b10:   return 180;
            default: return 220;
        endcase
    endfunction
endpackage

// File: rtl/drw_regif.sv
// Module: drw_regif
// Decodes host bus writes into per-drawer request strobes and builds the
// combinational read data for the control and status registers.
// Assumes bus inputs and drawer status inputs are synchronous to clk.
module drw_regif
    import drw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        open_now,
    input  logic [1:0]        sense,
    input  logic [1:0]        pol_inv,
    output logic [1:0]        req,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [1:0]        corr;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] stat_view;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[3:0]};

    // Request strobes: only a write to the control address counts
    always_comb begin
        req = 2'b00;
        if (bus_wr && bus_addr == CTRL_ADDR) begin
            req[0] = bus_wdata[CTRL_BIT_D1];
            req[1] = bus_wdata[CTRL_BIT_D2];
        end
    end

    // Per-drawer polarity correction and placement in the status byte
    for (genvar i = 0; i < 2; i++) begin : g_stat
        assign corr[i] = sense[i] ^ pol_inv[i];
    end

    // Assemble the register views from the current outputs and status
    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_BIT_D1] = open_now[0];
        ctrl_view[CTRL_BIT_D2] = open_now[1];
        stat_view = '0;
        stat_view[STAT_BIT_D1]     = corr[0];
        stat_view[STAT_BIT_D1 - 1] = corr[1];
    end

    // Read multiplexer: zero when idle or when the address is unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == CTRL_ADDR)      bus_rdata = ctrl_view;
            else if (bus_addr == STAT_ADDR) bus_rdata = stat_view;
        end
    end

    // R9
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);
    // R8
    stat_unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[7:4] == 4'd0 && bus_rdata[1:0] == 2'd0));
    // R11
    no_req_off_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != CTRL_ADDR) |-> req == 2'b00);
endmodule

// File: rtl/drw_timer.sv
// Module: drw_timer
// Times one pulse: a prescaler makes a millisecond tick and a counter
// runs up to the length chosen by the duration code at start.
// Assumes start arrives only while the timer is idle.
module drw_timer
    import drw_pkg::*;
#(
    parameter int TICK_DIV = 50_000,
    localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] sel,
    output logic       running,
    output logic       done
);
    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic [MS_W-1:0]  limit;
    logic             tick;

    assign tick = (pre_cnt == PRE_W'(TICK_DIV - 1));
    assign done = running && tick && (ms_cnt == limit - MS_W'(1));

    // Prescaler, millisecond counter and latched length of the current pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre_cnt <= '0;
            ms_cnt  <= '0;
            limit   <= '0;
        end else if (start) begin
            running <= 1'b1;
            pre_cnt <= '0;
            ms_cnt  <= '0;
            limit   <= MS_W'(pulse_ms(sel));
        end else if (running) begin
            if (done) begin
                running <= 1'b0;
            end else if (tick) begin
                pre_cnt <= '0;
                ms_cnt  <= ms_cnt + MS_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && ms_cnt == '0 && pre_cnt == '0));
    // R2
    ms_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ms_cnt < limit);
    // R2
    done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !running);
endmodule

// File: rtl/drw_arbiter.sv
// Module: drw_arbiter
// Interlock between the two drawers: grants one pulse at a time, queues
// a request for the idle drawer, and drops repeats for the running one.
// Drawer 1 wins when both are wanted in the same idle cycle.
module drw_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       done,
    output logic [1:0] active,
    output logic       start
);
    logic [1:0] pend;
    logic [1:0] cand;
    logic [1:0] pick;

    // Pick the next drawer to grant from pending and new requests
    always_comb begin
        cand  = pend | req;
        pick  = cand[0] ? 2'b01 : (cand[1] ? 2'b10 : 2'b00);
        start = (active == 2'b00) && (cand != 2'b00);
    end

    // Grant, release and pending bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 2'b00;
            pend   <= 2'b00;
        end else if (active != 2'b00) begin
            pend <= pend | (req & ~active);
            if (done) active <= 2'b00;
        end else if (start) begin
            active <= pick;
            pend   <= cand & ~pick;
        end
    end

    // R3
    one_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));
    // R5
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active != 2'b00 && !done) |=> active == $past(active));
    // R4
    gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> active == 2'b00);
endmodule

// File: rtl/drawer_pulse_ctrl.sv
// Module: drawer_pulse_ctrl (top)
// Dual cash drawer release controller: register decode, interlocked pulse
// scheduling, millisecond pulse timer and polarity-corrected status readback.
// Assumes CLK_HZ is a multiple of 1000 and all inputs are synchronous to clk.
module drawer_pulse_ctrl
    import drw_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    localparam int TICK_DIV = CLK_HZ / 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        dur_sel,
    input  logic [1:0]        pol_inv,
    input  logic [1:0]        drw_sense,
    output logic [1:0]        drw_open
);
    logic [1:0] req;
    logic       start;
    logic       done;
    logic       running;
    logic       unused_running;

    assign unused_running = running;

    drw_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .open_now  (drw_open),
        .sense     (drw_sense),
        .pol_inv   (pol_inv),
        .req       (req),
        .bus_rdata (bus_rdata)
    );

    drw_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .done   (done),
        .active (drw_open),
        .start  (start)
    );

    drw_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sel     (dur_sel),
        .running (running),
        .done    (done)
    );

    // R3
    timer_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running == (drw_open != 2'b00));
endmodule

// File: tb/drawer_pulse_ctrl_tb_top.sv
// Bench: behavioural cycle model of the drawer controller, compared every clock.
module drawer_pulse_ctrl_tb_top;
    localparam int CLK_HZ = 20_000;
    localparam int DIV    = CLK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] dur_sel = 2'b00;
    logic [1:0] pol_inv = 2'b00;
    logic [1:0] drw_sense = 2'b00;
    logic [1:0] drw_open;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R10";
    bit    finished = 1'b0;

    // reference model state
    int m_act = -1;
    int m_rem = 0;
    bit m_pend[2] = '{0, 0};

    always #2 clk = ~clk;

    drawer_pulse_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dur_sel(dur_sel), .pol_inv(pol_inv), .drw_sense(drw_sense),
        .drw_open(drw_open)
    );

    function automatic int ms_of(input logic [1:0] c);
        int t[4] = '{140, 100, 180, 220};
        return t[c];
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        bit r[2];
        r[0] = bus_wr && bus_addr == 10'h328 && bus_wdata[4];
        r[1] = bus_wr && bus_addr == 10'h328 && bus_wdata[5];
        if (!rst_n) begin
            m_act = -1; m_rem = 0; m_pend = '{0, 0};
        end else if (m_act >= 0) begin
            for (int d = 0; d < 2; d++) if (r[d] && d != m_act) m_pend[d] = 1;
            m_rem--;
            if (m_rem == 0) m_act = -1;
        end else if (m_pend[0] || r[0]) begin
            m_act = 0; m_rem = ms_of(dur_sel) * DIV;
            m_pend[0] = 0; m_pend[1] = m_pend[1] | r[1];
        end else if (m_pend[1] || r[1]) begin
            m_act = 1; m_rem = ms_of(dur_sel) * DIV; m_pend[1] = 0;
        end
    end

    // Compare outputs against the model on every falling edge
    always @(negedge clk) begin
        logic [1:0] exp_open;
        exp_open = (m_act == 0) ? 2'b01 : (m_act == 1) ? 2'b10 : 2'b00;
        check(drw_open == exp_open, cur_req, drw_open, exp_open);
        check(!(drw_open[0] && drw_open[1]), "R3", drw_open, 0);
        if (!bus_rd) check(bus_rdata == 8'h00, "R9", bus_rdata, 0);
    end

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [7:0] exp, input string rq);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(bus_rdata == exp, rq, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_act >= 0 || m_pend[0] || m_pend[1]) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";
        check(drw_open == 2'b00, "R10", drw_open, 0);
        rst_n = 1'b1;
        rd_chk(10'h328, 8'h00, "R10");

        // R1 drawer 1, default code, R2 140 ms
        cur_req = "R1";
        dur_sel = 2'b00;
        wr(10'h328, 8'h10);
        rd_chk(10'h328, 8'h10, "R7");
        cur_req = "R2";
        wait_idle();

        // R1 drawer 2, R2 100 ms
        cur_req = "R1";
        dur_sel = 2'b01;
        wr(10'h328, 8'h20);
        rd_chk(10'h328, 8'h20, "R7");
        cur_req = "R2";
        wait_idle();

        // R4 pending other drawer, R5 repeat ignored, 180 ms
        cur_req = "R4";
        dur_sel = 2'b10;
        wr(10'h328, 8'h10);
        wait_cycles(500);
        wr(10'h328, 8'h20);
        cur_req = "R5";
        wait_cycles(1000);
        wr(10'h328, 8'h10);
        cur_req = "R4";
        wait_idle();

        // R6 both bits in one write, 220 ms
        cur_req = "R6";
        dur_sel = 2'b11;
        wr(10'h328, 8'h30);
        wait_idle();

        // R7 zero write and R11 foreign address
        cur_req = "R7";
        wr(10'h328, 8'hCF);
        wait_cycles(20);
        cur_req = "R11";
        wr(10'h329, 8'h30);
        wr(10'h32D, 8'h30);
        wait_cycles(20);
        check(drw_open == 2'b00, "R11", drw_open, 0);

        // R8 status with all sense and polarity combinations
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e;
            drw_sense = k[1:0];
            pol_inv   = k[3:2];
            e = '0;
            e[3] = k[0] ^ k[2];
            e[2] = k[1] ^ k[3];
            rd_chk(10'h32D, e, "R8");
        end

        // R9 unmapped addresses read zero
        rd_chk(10'h000, 8'h00, "R9");
        rd_chk(10'h32C, 8'h00, "R9");

        // R10 reset mid-pulse drops active and pending
        cur_req = "R10";
        dur_sel = 2'b01;
        wr(10'h328, 8'h10);
        wr(10'h328, 8'h20);
        wait_cycles(100);
        rst_n = 1'b0;
        wait_cycles(2);
        check(drw_open == 2'b00, "R10", drw_open, 0);
        rst_n = 1'b1;
        wait_cycles(3000);
        check(drw_open == 2'b00, "R10", drw_open, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule